// File: doc/BRIEF.md
# Backup Battery Health Monitor

This block runs a periodic load test on a backup battery and keeps a latched low-battery warning. Whenever main supply power is present, it waits a short recovery delay and then runs a first test. It then runs a further test once per day. During each test it turns on a test-load enable for a fixed window and watches a threshold comparator input on every millisecond tick. At the end of the window the warning is set if any sample read low, and released if every sample read good.

All intervals are counted in ticks of an external 1 ms strobe. They are parameters, so that simulation can use shortened values. The warning pin is modelled as an open-drain pull-down enable. A battery-replaced pulse clears the warning and starts a fresh test at once.

When supply power fails, the test load is removed, any test in progress and the day count are dropped, and the warning pin is released. The latched warning value itself is kept. A new test runs after every power-up, even when the warning is already latched.

Top module: `batt_health_mon`

## Requirements
- R1: While reset is held, and after it is released with supply power absent, `load_en` and `warn_pull` are both 0.
- R2: After the first clock edge that sees `supply_ok` high, `load_en` rises at the edge that carries the `RECOVER_TICKS`-th `tick_1ms`.
- R3: A test keeps `load_en` at 1 for exactly `TEST_TICKS` ticks. `load_en` is 0 at every other time.
- R4: A test that samples `batt_low`=1 on any tick of its window sets the warning when the window ends. `batt_low` has no effect outside a test window.
- R5: A test whose samples all read `batt_low`=0 releases the warning when its window ends.
- R6: Between tests the warning keeps its value.
- R7: The next test begins `PERIOD_TICKS` ticks after the previous test ends.
- R8: The first clock edge with `supply_ok` low drops `load_en`, aborts the test and its samples, and clears the interval count. `warn_pull` is 0 while `supply_ok` is low. The latched warning is shown again once supply returns.
- R9: Every power-up runs a test after the recovery delay, whether or not the warning is latched.
- R10: A `batt_swap` pulse clears the warning at the next edge. Between tests it starts a test at once. During a test it restarts the window and discards the samples taken so far. This also applies when the pulse coincides with the final tick of a test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle strobe once per millisecond |
| supply_ok | input | 1 | Main supply is within tolerance |
| batt_low | input | 1 | Comparator: battery is below its trip voltage |
| batt_swap | input | 1 | One-cycle pulse: battery has been replaced |
| load_en | output | 1 | Connects the battery test load |
| warn_pull | output | 1 | Open-drain enable; 1 pulls the active-low warning pin low |

## Verification
Two pairs of events can fall in the same clock cycle. A replacement pulse can arrive on the very tick that would end a test. The bench provokes this after a window in which `batt_low` read 1. The result passes only if the warning stays clear and `load_en` stays high for a full fresh window. A supply loss can also arrive on the tick that would start a daily test. The bench judges that case by `load_en` staying 0.

// File: rtl/battmon_pkg.sv
package battmon_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_TEST    = 2'd2,
    ST_WAIT    = 2'd3
  } mon_state_t;
endpackage

// File: rtl/battmon_interval.sv
module battmon_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == limit_i - 1'b1);

  // R7: the sequencer clears the count on every expiry, so it never reaches the limit
  a_r7_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit_i);
endmodule

// File: rtl/battmon_flag.sv
module battmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic warn_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     warn_o <= 1'b0;
    else if (clr_i) warn_o <= 1'b0;
    else if (set_i) warn_o <= 1'b1;
  end

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !warn_o);

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(warn_o));
endmodule

// File: rtl/battmon_seq.sv
module battmon_seq
  import battmon_pkg::*;
#(
  parameter int W             = 8,
  parameter int RECOVER_TICKS = 125,
  parameter int TEST_TICKS    = 1000,
  parameter int PERIOD_TICKS  = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         tick_i,
  input  logic         batt_low,
  input  logic         swap_i,
  input  logic         expire_i,
  output logic         clr_o,
  output logic [W-1:0] limit_o,
  output mon_state_t   state_o,
  output logic         set_warn_o,
  output logic         clr_warn_o
);
  localparam logic [W-1:0] L_REC  = W'(RECOVER_TICKS);
  localparam logic [W-1:0] L_TEST = W'(TEST_TICKS);
  localparam logic [W-1:0] L_PER  = W'(PERIOD_TICKS);

  mon_state_t state_q, nxt;
  logic seen_q;
  logic done, verdict;

  always_comb begin
    nxt     = state_q;
    clr_o   = 1'b0;
    done    = 1'b0;
    verdict = 1'b0;
    if (!supply_ok) begin
      nxt   = ST_OFF;
      clr_o = 1'b1;
    end else begin
      case (state_q)
        ST_OFF: begin
          nxt   = ST_RECOVER;
          clr_o = 1'b1;
        end
        ST_RECOVER: if (expire_i) begin
          nxt   = ST_TEST;
          clr_o = 1'b1;
        end
        ST_TEST: begin
          if (swap_i) begin
            clr_o = 1'b1;
          end else if (expire_i) begin
            nxt     = ST_WAIT;
            clr_o   = 1'b1;
            done    = 1'b1;
            verdict = seen_q | batt_low;
          end
        end
        ST_WAIT: if (swap_i || expire_i) begin
          nxt   = ST_TEST;
          clr_o = 1'b1;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          seen_q <= 1'b0;
    else if (!supply_ok || state_q != ST_TEST || swap_i) seen_q <= 1'b0;
    else if (tick_i && batt_low)                         seen_q <= 1'b1;
  end

  always_comb begin
    case (state_q)
      ST_TEST: limit_o = L_TEST;
      ST_WAIT: limit_o = L_PER;
      default: limit_o = L_REC;
    endcase
  end

  assign state_o    = state_q;
  assign set_warn_o = done & verdict;
  assign clr_warn_o = (done & ~verdict) | swap_i;

  a_r2_wait_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOVER && !expire_i) |=> state_q != ST_TEST);

  a_r8_off_when_unsupplied: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state_q == ST_OFF && !seen_q));

  a_r9_powerup_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && supply_ok) |=> state_q == ST_RECOVER);

  a_r10_swap_starts_test: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_i && supply_ok && state_q == ST_WAIT) |=> state_q == ST_TEST);
endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon
  import battmon_pkg::*;
#(
  parameter int RECOVER_TICKS = 125,
  parameter int TEST_TICKS    = 1000,
  parameter int PERIOD_TICKS  = 86_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic supply_ok,
  input  logic batt_low,
  input  logic batt_swap,
  output logic load_en,
  output logic warn_pull
);
  localparam int MAX_A = (RECOVER_TICKS > TEST_TICKS) ? RECOVER_TICKS : TEST_TICKS;
  localparam int MAX_T = (MAX_A > PERIOD_TICKS) ? MAX_A : PERIOD_TICKS;
  localparam int W     = $clog2(MAX_T + 1);

  logic         clr, expire, set_warn, clr_warn, warn_q;
  logic [W-1:0] limit;
  mon_state_t   state;

  battmon_interval #(.W(W)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .tick_i   (tick_1ms),
    .limit_i  (limit),
    .expire_o (expire)
  );

  battmon_seq #(
    .W             (W),
    .RECOVER_TICKS (RECOVER_TICKS),
    .TEST_TICKS    (TEST_TICKS),
    .PERIOD_TICKS  (PERIOD_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .tick_i     (tick_1ms),
    .batt_low   (batt_low),
    .swap_i     (batt_swap),
    .expire_i   (expire),
    .clr_o      (clr),
    .limit_o    (limit),
    .state_o    (state),
    .set_warn_o (set_warn),
    .clr_warn_o (clr_warn)
  );

  battmon_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_warn),
    .clr_i  (clr_warn),
    .warn_o (warn_q)
  );

  assign load_en   = (state == ST_TEST);
  assign warn_pull = warn_q & supply_ok;

  a_r8_load_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !load_en);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!load_en && !warn_q));
endmodule

// File: tb/sim_batt_health_mon.sv
module sim_batt_health_mon;
  localparam int REC = 3;
  localparam int TST = 4;
  localparam int PER = 10;
  localparam int NV  = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sup = 1'b0, low = 1'b0, swp = 1'b0;
  logic load_en, warn_pull;
  int   n_checks = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  batt_health_mon #(.RECOVER_TICKS(REC), .TEST_TICKS(TST), .PERIOD_TICKS(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .supply_ok(sup),
    .batt_low(low), .batt_swap(swp), .load_en(load_en), .warn_pull(warn_pull)
  );

  // [19] supply [18] batt_low [17] swap [16:9] ticks [8:5] requirement [1] load [0] warn
  function automatic logic [19:0] mk(logic s, logic l, logic w, int n, int r, logic el, logic ew);
    return {s, l, w, 8'(n), 4'(r), 3'b000, el, ew};
  endfunction

  localparam logic [19:0] VEC [NV] = '{
    mk(1,0,0, 2, 2, 0,0),  // R2 still recovering
    mk(1,0,0, 1, 2, 1,0),  // R2 test begins
    mk(1,1,0, 3, 3, 1,0),  // R3 window still open
    mk(1,1,0, 1, 4, 0,1),  // R4 low sample sets warning
    mk(1,0,0, 9, 6, 0,1),  // R6 sticky between tests
    mk(1,0,0, 1, 7, 1,1),  // R7 daily test
    mk(1,0,0, 4, 5, 0,0),  // R5 good test releases
    mk(1,1,0,10, 4, 1,0),  // R4 comparator ignored while waiting
    mk(1,1,0, 4, 4, 0,1),  // R4
    mk(1,0,1, 0,10, 1,0),  // R10 swap clears and tests at once
    mk(1,0,0, 4, 5, 0,0),  // R5
    mk(1,1,0,10, 7, 1,0),  // R7
    mk(1,1,0, 4, 4, 0,1),  // R4
    mk(0,1,0, 0, 8, 0,0),  // R8 pin released without supply
    mk(0,1,0,20, 8, 0,0),  // R8 no tests while off
    mk(1,0,0, 0, 8, 0,1),  // R8 latch shown again
    mk(1,0,0, 3, 9, 1,1),  // R9 power-up test despite warning
    mk(1,0,0, 4, 5, 0,0),  // R5
    mk(1,0,0,10, 7, 1,0),  // R7
    mk(1,1,0, 2, 3, 1,0),  // R3 mid-window
    mk(0,0,0, 0, 8, 0,0),  // R8 abort drops load
    mk(1,0,0, 3, 9, 1,0),  // R9
    mk(1,0,0, 4, 8, 0,0),  // R8 aborted samples were discarded
    mk(1,0,0, 9, 7, 0,0),  // R7 day count restarted
    mk(1,0,0, 1, 7, 1,0)   // R7
  };

  task automatic check(input int req, input logic el, input logic ew);
    n_checks++;
    if (load_en !== el || warn_pull !== ew) begin
      n_fail++;
      $display("FAIL R%0d: load_en=%b warn_pull=%b, expected load_en=%b warn_pull=%b",
               req, load_en, warn_pull, el, ew);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1: watchdog expired, run still active, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0);  // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1, 1'b0, 1'b0);  // R1 after reset, no supply

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sup = VEC[i][19];
      low = VEC[i][18];
      swp = VEC[i][17];
      @(negedge clk);
      swp = 1'b0;
      for (int k = 0; k < int'(VEC[i][16:9]); k++) do_tick();
      @(negedge clk);
      check(int'(VEC[i][8:5]), VEC[i][1], VEC[i][0]);
    end

    // R10: replacement coincides with the final tick of a failing window
    low = 1'b1;
    repeat (3) do_tick();
    @(negedge clk);
    tick = 1'b1;
    swp  = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    swp  = 1'b0;
    @(negedge clk);
    check(10, 1'b1, 1'b0);
    low = 1'b0;
    repeat (3) do_tick();
    @(negedge clk);
    check(10, 1'b1, 1'b0);  // R10 window was restarted
    do_tick();
    @(negedge clk);
    check(5, 1'b0, 1'b0);   // R5

    // R8: supply loss on the tick that would start the daily test
    repeat (9) do_tick();
    @(negedge clk);
    tick = 1'b1;
    sup  = 1'b0;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    check(8, 1'b0, 1'b0);

    finish_run();
  end
endmodule